// File: doc/BRIEF.md
# Paged Address Translator with Page Protection

The block sits between a 16-bit CPU and a 24-bit physical address space. The top four bits of each logical address select one of sixteen page descriptors. The low twelve bits are added to that descriptor's 24-bit base to form the physical address. Each descriptor also carries three protection bits: one for writes, one for instruction fetches and one for data reads. An access that breaks a protection bit is suppressed. It also raises a sticky error flag and pulls an active-low interrupt low. Both stay set until software reads the status register.

Software fills the descriptor table through a small register port. A write to the control register names one of eight map images held in a byte-wide SRAM, together with a direction. The sequencer then walks all 64 bytes of that image, one byte per clock. It either loads the bytes into the table or writes the table out to the image. While it runs, the busy output is high and CPU translations stall. A base value of 0xFF0000 marks a page with nothing behind it. An access to such a page is flagged as unmapped and is not passed on.

Top module: `xmap_top`

## Requirements
- R1: After reset, busy is 0, irq_n is 1, the status reads 0x00, and every page has base 0xFF0000 with no protection, so any request is reported unmapped.
- R2: The physical address is the base of page cpu_addr[15:12] plus cpu_addr[11:0], with carries into the upper bits and wrap modulo 2^24. It is valid combinationally in the cycle of the request.
- R3: A descriptor is four bytes. Byte 0 bit 7 is write-protect, bit 6 is fetch-protect and bit 5 is read-protect; bits 4:0 are ignored on load. Bytes 1, 2 and 3 are bits 23:16, 15:8 and 7:0 of the base.
- R4: A permitted request to a page whose base is exactly 0xFF0000 gives phys_unmapped=1, phys_valid=0 and phys_we=0.
- R5: A control write with reg_wdata[0]=1 loads map image reg_wdata[3:1] into the table. Bits 7:4 are ignored. busy rises at the next edge and stays high for exactly 64 cycles. Step k (0..63) reads SRAM byte image*64+k, which is entry k/4, byte k%4. SRAM read data is taken in the same cycle as its address.
- R6: A control write with reg_wdata[0]=0 stores the table into the image with sram_we high on each of the 64 steps. Byte 0 is written as {W,X,R,00000}. No other SRAM byte changes.
- R7: A write (kind 01) to a write-protected page, a fetch (kind 10) to a fetch-protected page, or a read to a read-protected page is a violation. It gives phys_valid=0 and phys_we=0. At the next edge it sets status bit 7, 6 or 5 respectively. Flags accumulate, and status bits 4:0 read 0.
- R8: irq_n goes low at the edge after a violation and stays low until reg_rd. reg_rdata always shows the status. reg_rd clears the flags at its edge, except a flag set by a violation in that same cycle, which is kept.
- R9: While busy, requests give phys_valid=0, phys_we=0 and phys_unmapped=0, and raise no flags. A control write while busy is ignored and does not lengthen the transfer.
- R10: cpu_kind encodes 00 read, 01 write, 10 fetch; 11 is treated as a read. phys_we is 1 only for a permitted, mapped write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU access request this cycle |
| cpu_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| cpu_addr | input | 16 | Logical address |
| phys_valid | output | 1 | Translated access may proceed |
| phys_we | output | 1 | Write strobe for a permitted write |
| phys_unmapped | output | 1 | Request hit an unmapped page |
| phys_addr | output | 24 | Translated physical address |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Status register read strobe (clears flags) |
| reg_wdata | input | 8 | Control value: [3:1] image number, [0] 1=load 0=store |
| reg_rdata | output | 8 | Status: [7] write, [6] fetch, [5] read violation |
| irq_n | output | 1 | Violation interrupt, active low |
| busy | output | 1 | Map transfer in progress |
| sram_addr | output | 9 | SRAM byte address for the transfer |
| sram_we | output | 1 | SRAM write strobe |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid in the same cycle as the address |

## Verification
Translation results (phys_addr, phys_valid, phys_we, phys_unmapped) are due in the cycle of the request. The bench drives them on the falling edge and samples them one nanosecond later. Violation flags and irq_n change one edge after the offending cycle, and a status read clears at its own edge. The bench therefore checks those only after the next rising edge has passed. busy rises one edge after a control write, and its duration is measured by counting falling edges while it is high, which must give exactly 64. Stored images are compared byte by byte after busy falls.

// File: rtl/xmap_pkg.sv
package xmap_pkg;

    localparam int LA_W       = 16;
    localparam int PA_W       = 24;
    localparam int PAGE_W     = 4;
    localparam int OFF_W      = LA_W - PAGE_W;
    localparam int N_PAGES    = 1 << PAGE_W;
    localparam int ENT_BYTES  = 4;
    localparam int BSEL_W     = $clog2(ENT_BYTES);
    localparam int STEP_W     = PAGE_W + BSEL_W;
    localparam int N_STEPS    = N_PAGES * ENT_BYTES;
    localparam int FILE_W     = 3;
    localparam int SRAM_AW    = FILE_W + STEP_W;
    localparam int KIND_W     = 2;

    localparam logic [PA_W-1:0] UNMAPPED_BASE = 24'hFF0000;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic wp;
        logic xp;
        logic rp;
    } prot_t;

    typedef struct packed {
        prot_t            prot;
        logic [PA_W-1:0]  base;
    } page_ent_t;

    typedef struct packed {
        logic wr_err;
        logic x_err;
        logic rd_err;
    } viol_t;

    typedef struct packed {
        logic             valid;
        logic             we;
        logic             unmapped;
        logic [PA_W-1:0]  addr;
    } xlate_res_t;

    localparam page_ent_t RESET_ENT = '{prot: '0, base: UNMAPPED_BASE};

    function automatic logic [7:0] pack_prot_byte(prot_t p);
        return {p.wp, p.xp, p.rp, 5'b00000};
    endfunction

    function automatic logic [SRAM_AW-1:0] image_addr(logic [FILE_W-1:0] img,
                                                       logic [STEP_W-1:0] step);
        return {img, step};
    endfunction

endpackage

// File: rtl/xmap_table.sv
module xmap_table
    import xmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_idx,
    input  logic [BSEL_W-1:0]  wr_byte,
    input  logic [7:0]         wr_data,
    input  logic [PAGE_W-1:0]  lk_idx,
    output page_ent_t          lk_ent,
    input  logic [PAGE_W-1:0]  rd_idx,
    input  logic [BSEL_W-1:0]  rd_byte,
    output logic [7:0]         rd_data
);

    page_ent_t ents [N_PAGES];

    generate
        for (genvar g = 0; g < N_PAGES; g++) begin : g_page
            page_ent_t ent_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= RESET_ENT;
                end else if (wr_en && wr_idx == PAGE_W'(g)) begin
                    case (wr_byte)
                        2'd0:    ent_q.prot       <= prot_t'(wr_data[7:5]);
                        2'd1:    ent_q.base[23:16] <= wr_data;
                        2'd2:    ent_q.base[15:8]  <= wr_data;
                        default: ent_q.base[7:0]   <= wr_data;
                    endcase
                end
            end
            assign ents[g] = ent_q;
        end
    endgenerate

    assign lk_ent = ents[lk_idx];

    always_comb begin
        case (rd_byte)
            2'd0:    rd_data = pack_prot_byte(ents[rd_idx].prot);
            2'd1:    rd_data = ents[rd_idx].base[23:16];
            2'd2:    rd_data = ents[rd_idx].base[15:8];
            default: rd_data = ents[rd_idx].base[7:0];
        endcase
    end

endmodule

// File: rtl/xmap_xlate.sv
module xmap_xlate
    import xmap_pkg::*;
(
    input  logic               req,
    input  logic [KIND_W-1:0]  kind,
    input  logic [LA_W-1:0]    addr,
    input  logic               stall,
    input  page_ent_t          ent,
    output xlate_res_t         res,
    output viol_t              viol
);

    acc_kind_e kind_e;
    logic      active;
    logic      is_wr;
    logic      is_fetch;
    logic      is_rd;
    logic      any_viol;
    logic      unmapped_pg;

    always_comb begin
        kind_e   = acc_kind_e'(kind);
        active   = req && !stall;
        is_wr    = (kind_e == ACC_WRITE);
        is_fetch = (kind_e == ACC_FETCH);
        is_rd    = !is_wr && !is_fetch;

        viol.wr_err = active && is_wr    && ent.prot.wp;
        viol.x_err  = active && is_fetch && ent.prot.xp;
        viol.rd_err = active && is_rd    && ent.prot.rp;
        any_viol    = viol.wr_err || viol.x_err || viol.rd_err;

        unmapped_pg  = (ent.base == UNMAPPED_BASE);
        res.addr     = ent.base + {{(PA_W-OFF_W){1'b0}}, addr[OFF_W-1:0]};
        res.unmapped = active && !any_viol && unmapped_pg;
        res.valid    = active && !any_viol && !unmapped_pg;
        res.we       = res.valid && is_wr;
    end

endmodule

// File: rtl/xmap_seq.sv
module xmap_seq
    import xmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr,
    input  logic [7:0]          ctl_data,
    output logic                busy,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                sram_we,
    output logic                tbl_wr_en,
    output logic [PAGE_W-1:0]   tbl_idx,
    output logic [BSEL_W-1:0]   tbl_byte
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    logic                busy_q;
    logic                load_q;
    logic [FILE_W-1:0]   img_q;
    logic [STEP_W-1:0]   step_q;
    logic                unused_ctl_bits;

    assign unused_ctl_bits = ^ctl_data[7:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            load_q <= 1'b0;
            img_q  <= '0;
            step_q <= '0;
        end else if (!busy_q) begin
            if (ctl_wr) begin
                busy_q <= 1'b1;
                load_q <= ctl_data[0];
                img_q  <= ctl_data[FILE_W:1];
                step_q <= '0;
            end
        end else begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_q;
    assign sram_addr = image_addr(img_q, step_q);
    assign sram_we   = busy_q && !load_q;
    assign tbl_wr_en = busy_q && load_q;
    assign tbl_idx   = step_q[STEP_W-1:BSEL_W];
    assign tbl_byte  = step_q[BSEL_W-1:0];

endmodule

// File: rtl/xmap_status.sv
module xmap_status
    import xmap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  viol_t  viol_in,
    input  logic   rd_strobe,
    output viol_t  flags,
    output logic   irq_n
);

    viol_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= viol_t'((rd_strobe ? 3'b000 : flags_q) | viol_in);
        end
    end

    assign flags = flags_q;
    assign irq_n = !(flags_q.wr_err || flags_q.x_err || flags_q.rd_err);

endmodule

// File: rtl/xmap_top.sv
module xmap_top
    import xmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req,
    input  logic [KIND_W-1:0]   cpu_kind,
    input  logic [LA_W-1:0]     cpu_addr,
    output logic                phys_valid,
    output logic                phys_we,
    output logic                phys_unmapped,
    output logic [PA_W-1:0]     phys_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                irq_n,
    output logic                busy,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                sram_we,
    output logic [7:0]          sram_wdata,
    input  logic [7:0]          sram_rdata
);

    page_ent_t           cur_ent;
    xlate_res_t          res;
    viol_t               viol;
    viol_t               flags;
    logic                viol_any;
    logic                tbl_wr_en;
    logic [PAGE_W-1:0]   tbl_idx;
    logic [BSEL_W-1:0]   tbl_byte;

    xmap_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (reg_wr),
        .ctl_data  (reg_wdata),
        .busy      (busy),
        .sram_addr (sram_addr),
        .sram_we   (sram_we),
        .tbl_wr_en (tbl_wr_en),
        .tbl_idx   (tbl_idx),
        .tbl_byte  (tbl_byte)
    );

    xmap_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_idx),
        .wr_byte (tbl_byte),
        .wr_data (sram_rdata),
        .lk_idx  (cpu_addr[LA_W-1:OFF_W]),
        .lk_ent  (cur_ent),
        .rd_idx  (tbl_idx),
        .rd_byte (tbl_byte),
        .rd_data (sram_wdata)
    );

    xmap_xlate u_xlate (
        .req   (cpu_req),
        .kind  (cpu_kind),
        .addr  (cpu_addr),
        .stall (busy),
        .ent   (cur_ent),
        .res   (res),
        .viol  (viol)
    );

    xmap_status u_status (
        .clk       (clk),
        .rst       (rst),
        .viol_in   (viol),
        .rd_strobe (reg_rd),
        .flags     (flags),
        .irq_n     (irq_n)
    );

    assign viol_any      = viol.wr_err || viol.x_err || viol.rd_err;
    assign phys_valid    = res.valid;
    assign phys_we       = res.we;
    assign phys_unmapped = res.unmapped;
    assign phys_addr     = res.addr;
    assign reg_rdata     = {flags, 5'b00000};

endmodule

// File: rtl/xmap_chk.sv
module xmap_chk
    import xmap_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic phys_valid,
    input logic phys_we,
    input logic phys_unmapped,
    input logic reg_wr,
    input logic reg_rd,
    input logic irq_n,
    input logic busy,
    input logic sram_we,
    input logic viol_any
);

    logic [STEP_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R5: transfer lasts exactly N_STEPS cycles
    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < (STEP_W+1)'(N_STEPS)));
    a_r5_busy_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len == (STEP_W+1)'(N_STEPS - 1)) |=> !busy);
    a_r5_busy_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr));

    // R6: SRAM is written only during a transfer
    a_r6_sram_we_busy: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> busy);

    // R7: violating access is suppressed and raises the interrupt
    a_r7_suppress: assert property (@(posedge clk) disable iff (rst)
        viol_any |-> (!phys_valid && !phys_we));
    a_r7_irq_set: assert property (@(posedge clk) disable iff (rst)
        viol_any |=> !irq_n);

    // R8: interrupt held until read, cleared by a clean read
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !reg_rd) |=> !irq_n);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !viol_any) |=> irq_n);

    // R4: unmapped page gives no access
    a_r4_unmapped_excl: assert property (@(posedge clk) disable iff (rst)
        phys_unmapped |-> (!phys_valid && !phys_we));

    // R9: stall while busy
    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!phys_valid && !phys_unmapped && !viol_any));

    // R10: write strobe only on a valid access
    a_r10_we_valid: assert property (@(posedge clk) disable iff (rst)
        phys_we |-> phys_valid);

endmodule

bind xmap_top xmap_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .phys_valid    (phys_valid),
    .phys_we       (phys_we),
    .phys_unmapped (phys_unmapped),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .irq_n         (irq_n),
    .busy          (busy),
    .sram_we       (sram_we),
    .viol_any      (viol_any)
);

// File: tb/xmap_top_tb_top.sv
module xmap_top_tb_top;

    localparam logic [1:0] K_R = 2'b00;
    localparam logic [1:0] K_W = 2'b01;
    localparam logic [1:0] K_F = 2'b10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req;
    logic [1:0]  cpu_kind;
    logic [15:0] cpu_addr;
    logic        phys_valid, phys_we, phys_unmapped;
    logic [23:0] phys_addr;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        irq_n, busy;
    logic [8:0]  sram_addr;
    logic        sram_we;
    logic [7:0]  sram_wdata, sram_rdata;

    logic [7:0]  mem [512];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    xmap_top dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr),
        .phys_valid(phys_valid), .phys_we(phys_we),
        .phys_unmapped(phys_unmapped), .phys_addr(phys_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .busy(busy),
        .sram_addr(sram_addr), .sram_we(sram_we),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    assign sram_rdata = mem[sram_addr];
    always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [23:0] base_of(int i);
        case (i)
            0:  return 24'h000000;
            1:  return 24'h00FF80;
            2:  return 24'h123000;
            3:  return 24'h400000;
            4:  return 24'hABC000;
            5:  return 24'h050505;
            14: return 24'hFFFF00;
            15: return 24'hFF0000;
            default: return 24'(i * 24'h010100);
        endcase
    endfunction

    function automatic logic [2:0] prot_of(int i);
        case (i)
            2: return 3'b100;
            3: return 3'b010;
            4: return 3'b001;
            5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 200) begin
            n = n + 1;
            tick();
        end
    endtask

    task automatic clear_status();
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic [1:0]  k;
        logic        v;
        logic        u;
        logic [23:0] pa;
        logic [7:0]  st;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'h0123, 2'b00, 1'b1, 1'b0, 24'h000123, 8'h00},
        '{16'h1080, 2'b00, 1'b1, 1'b0, 24'h010000, 8'h00},
        '{16'h2010, 2'b01, 1'b0, 1'b0, 24'h000000, 8'h80},
        '{16'h2010, 2'b00, 1'b1, 1'b0, 24'h123010, 8'h00},
        '{16'h3FFF, 2'b10, 1'b0, 1'b0, 24'h000000, 8'h40},
        '{16'h3004, 2'b01, 1'b1, 1'b0, 24'h400004, 8'h00},
        '{16'h4000, 2'b00, 1'b0, 1'b0, 24'h000000, 8'h20},
        '{16'h4ABC, 2'b10, 1'b1, 1'b0, 24'hABCABC, 8'h00},
        '{16'h5000, 2'b01, 1'b0, 1'b0, 24'h000000, 8'h80},
        '{16'hEFFF, 2'b00, 1'b1, 1'b0, 24'h000EFF, 8'h00},
        '{16'hF000, 2'b00, 1'b0, 1'b1, 24'h000000, 8'h00},
        '{16'h7777, 2'b01, 1'b1, 1'b0, 24'h070E77, 8'h00}
    };

    initial begin
        int n;
        int bad;
        rst = 1'b1; cpu_req = 1'b0; cpu_kind = K_R; cpu_addr = 16'h0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
        for (int a = 0; a < 512; a++) mem[a] = 8'hA5;
        for (int i = 0; i < 16; i++) begin
            logic [23:0] b;
            b = base_of(i);
            mem[0*64 + i*4 + 0] = 8'h1F;
            mem[0*64 + i*4 + 1] = 8'h00;
            mem[0*64 + i*4 + 2] = 8'h00;
            mem[0*64 + i*4 + 3] = 8'h00;
            mem[3*64 + i*4 + 0] = {prot_of(i), 5'b10101};
            mem[3*64 + i*4 + 1] = b[23:16];
            mem[3*64 + i*4 + 2] = b[15:8];
            mem[3*64 + i*4 + 3] = b[7:0];
        end
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;
        #1;

        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 32'(busy), 32'h0);
        chk(irq_n == 1'b1, "R1 irq_n", 32'(irq_n), 32'h1);
        chk(reg_rdata == 8'h00, "R1 status", 32'(reg_rdata), 32'h0);
        cpu_req = 1'b1; cpu_kind = K_R; cpu_addr = 16'h1234;
        #1;
        chk(phys_unmapped && !phys_valid, "R1 pages unmapped",
            {30'b0, phys_unmapped, phys_valid}, 32'h2);
        @(negedge clk);
        cpu_req = 1'b0;

        // R5: load image 3, 64 busy cycles
        ctl_write(8'hF7);
        wait_idle(n);
        chk(n == 64, "R5 load busy cycles", 32'(n), 32'd64);

        // R2 R3 R4 R7 R8 R10: vector walk
        for (int v = 0; v < 12; v++) begin
            cpu_req = 1'b1; cpu_kind = VECS[v].k; cpu_addr = VECS[v].a;
            #1;
            chk(phys_valid == VECS[v].v, "R7 valid", 32'(phys_valid), 32'(VECS[v].v));
            chk(phys_unmapped == VECS[v].u, "R4 unmapped", 32'(phys_unmapped), 32'(VECS[v].u));
            chk(phys_we == (VECS[v].v && VECS[v].k == K_W), "R10 we",
                32'(phys_we), 32'(VECS[v].v && VECS[v].k == K_W));
            if (VECS[v].v)
                chk(phys_addr == VECS[v].pa, "R2 R3 phys_addr", 32'(phys_addr), 32'(VECS[v].pa));
            tick();
            cpu_req = 1'b0;
            #1;
            chk(reg_rdata == VECS[v].st, "R7 status flags", 32'(reg_rdata), 32'(VECS[v].st));
            chk(irq_n == (VECS[v].st == 8'h00), "R8 irq_n after access",
                32'(irq_n), 32'(VECS[v].st == 8'h00));
            @(negedge clk);
            clear_status();
            #1;
            chk(reg_rdata == 8'h00 && irq_n, "R8 cleared by read",
                {23'b0, irq_n, reg_rdata}, 32'h100);
            @(negedge clk);
        end

        // R7: flags accumulate; R10: kind 11 acts as read
        cpu_req = 1'b1; cpu_kind = K_W; cpu_addr = 16'h2000;
        tick();
        cpu_kind = 2'b11; cpu_addr = 16'h4000;
        #1;
        chk(!phys_valid, "R10 kind 11 read-protected", 32'(phys_valid), 32'h0);
        tick();
        cpu_req = 1'b0;
        #1;
        chk(reg_rdata == 8'hA0, "R7 accumulate", 32'(reg_rdata), 32'hA0);
        @(negedge clk);

        // R8: unread flag persists over idle cycles
        tick(); tick();
        chk(!irq_n && reg_rdata == 8'hA0, "R8 held", {23'b0, irq_n, reg_rdata}, 32'h0A0);

        // R8: violation in the same cycle as the read is kept
        reg_rd = 1'b1; cpu_req = 1'b1; cpu_kind = K_F; cpu_addr = 16'h3000;
        tick();
        reg_rd = 1'b0; cpu_req = 1'b0;
        #1;
        chk(reg_rdata == 8'h40 && !irq_n, "R8 same-cycle violation kept",
            {23'b0, irq_n, reg_rdata}, 32'h040);
        @(negedge clk);
        clear_status();

        // R6: store table into image 6
        ctl_write(8'h0C);
        wait_idle(n);
        chk(n == 64, "R6 store busy cycles", 32'(n), 32'd64);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            logic [23:0] b;
            b = base_of(i);
            if (mem[6*64 + i*4 + 0] != {prot_of(i), 5'b00000}) bad++;
            if (mem[6*64 + i*4 + 1] != b[23:16]) bad++;
            if (mem[6*64 + i*4 + 2] != b[15:8]) bad++;
            if (mem[6*64 + i*4 + 3] != b[7:0]) bad++;
        end
        chk(bad == 0, "R6 stored image", 32'(bad), 32'h0);
        bad = 0;
        for (int a = 5*64; a < 6*64; a++) if (mem[a] != 8'hA5) bad++;
        for (int a = 7*64; a < 8*64; a++) if (mem[a] != 8'hA5) bad++;
        chk(bad == 0, "R6 neighbours untouched", 32'(bad), 32'h0);

        // R9: stall during load, second control write ignored
        ctl_write(8'h01);
        reg_wr = 1'b1; reg_wdata = 8'h07;
        cpu_req = 1'b1; cpu_kind = K_W; cpu_addr = 16'h2010;
        #1;
        chk(!phys_valid && !phys_we && !phys_unmapped, "R9 stalled outputs",
            {29'b0, phys_valid, phys_we, phys_unmapped}, 32'h0);
        tick();
        reg_wr = 1'b0; cpu_req = 1'b0;
        wait_idle(n);
        chk(n + 1 == 64, "R9 write while busy ignored", 32'(n + 1), 32'd64);
        chk(reg_rdata == 8'h00 && irq_n, "R9 no flag while busy",
            {23'b0, irq_n, reg_rdata}, 32'h100);

        // R5: image 0 selected (base 0, no protection)
        cpu_req = 1'b1; cpu_kind = K_R; cpu_addr = 16'h1080;
        #1;
        chk(phys_valid && phys_addr == 24'h000080, "R5 image 0 selected",
            32'(phys_addr), 32'h000080);
        @(negedge clk);
        cpu_kind = K_W; cpu_addr = 16'h2010;
        #1;
        chk(phys_we && phys_addr == 24'h000010, "R3 low bits ignored, no protection",
            32'(phys_addr), 32'h000010);
        @(negedge clk);
        cpu_req = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule